// File: doc/BRIEF.md
# Two-Wire Control and Diagnostic Register Target

This block is a two-wire serial bus target that exposes a single byte-wide register to a host controller. A host write sets six control bits that drive the power and tone logic of a supply stage. A host read returns three of those control bits together with two live fault flags. The target works from oversampled copies of the clock and data lines. It synchronises and glitch-filters both lines, and it drives the data line only through an open-drain enable.

One strap input picks the lowest bit of the device address. A second, fixed address is always answered. An under-voltage lockout input silences the target entirely: it gives no acknowledge, the control register is forced to zero, and it stays zero until a later write. The register layout on write differs from the layout on read. Two write positions are test bits that are always dropped, and three read positions always return zero.

Top module: `ctl_reg_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 000101s (s = `addrStrap`) or 0001000; any other address gets no acknowledge, and the target leaves the bus alone until the next START.
- R2: Write layout, MSB first: bit7 `limitStatic`, bit6 `toneGate`, bit5 `toneCont`, bit4 `lineBoost`, bit3 `voltHigh`, bit2 `powerEn`; bits 1 and 0 are test bits, are discarded and affect no output.
- R3: A data byte takes effect on the SCL falling edge that ends its eighth bit. The target acknowledges every data byte on the ninth clock. Several data bytes in one transaction each take effect in turn.
- R4: Read layout, MSB first: bits 7..5 zero, bit4 `lineBoost`, bit3 `voltHigh`, bit2 `powerEn`, bit1 `overTemp`, bit0 `overLoad`. The flags are captured when the byte is loaded, on the SCL falling edge that ends the preceding acknowledge.
- R5: During a read, a master acknowledge makes the target load and send a fresh byte, and a master no-acknowledge makes it release SDA until the next START.
- R6: START (SDA falling while SCL is high) begins a new address phase from any state, including a repeated START inside a transfer; STOP (SDA rising while SCL is high) returns the target to idle.
- R7: While `lockout` is high, the target never drives SDA and all control outputs are zero; after `lockout` falls they stay zero until written.
- R8: After reset, all control outputs are zero and SDA is released.
- R9: The target changes its SDA drive only while the filtered SCL is low, except when it leaves a drive on START, STOP or lockout.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored and does not count as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| addrStrap | input | 1 | Selects the lowest bit of the device address |
| lockout | input | 1 | Under-voltage lockout, active high |
| overTemp | input | 1 | Over-temperature fault flag |
| overLoad | input | 1 | Output overload fault flag |
| sdaOe | output | 1 | Pulls SDA low when high |
| limitStatic | output | 1 | Static (1) or pulsed (0) current limit select |
| toneGate | output | 1 | Enables the tone output stage |
| toneCont | output | 1 | Keeps the tone on continuously |
| lineBoost | output | 1 | Raises the output voltage for line loss |
| voltHigh | output | 1 | Selects the higher output voltage |
| powerEn | output | 1 | Enables the power blocks |

## Verification
The assertions assume that a host changes SDA only while SCL is low, except to form START or STOP, so that a change of the target's own drive while SCL is high can come only from those events or from lockout. They also assume that each line level holds for longer than the filter window plus the synchroniser. The bench keeps every SCL phase at twenty system clocks, well beyond that window. It holds the fault flags steady for many cycles around each byte load, and it injects a deliberate short SCL pulse only while SDA is stable.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_W  = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadTx;
    logic shiftTx;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/ctlreg_linefilt.sv
module ctlreg_linefilt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int LINES       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] cleanOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [SYNC_STAGES-1:0] syncQ;
    logic [CNT_W-1:0]       runCnt;
    logic                   level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= '1;
        runCnt <= '0;
        level  <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn[g]};
        if (syncQ[SYNC_STAGES-1] == level) begin
          runCnt <= '0;
        end else if (runCnt == CNT_W'(FILT_LEN - 1)) begin
          level  <= ~level;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end

    assign cleanOut[g] = level;
  end
endmodule

// File: rtl/ctlreg_ctrl.sv
module ctlreg_ctrl
  import ctlreg_pkg::*;
#(
  parameter logic [5:0] OWN_ADDR_HI = 6'b000101,
  parameter logic [6:0] ALT_ADDR    = 7'b0001000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockout,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic              addrSel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpStrobe_t         stb,
  output logic              sdaOe
);
  localparam int BC_W = $clog2(BYTE_W + 1);

  busState_t       state;
  logic [BC_W-1:0] bitCnt;
  logic            sclQ, sdaQ, readMode, mAck;
  logic            sclRise, sclFall, startEv, stopEv, addrHit, byteDone;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startEv  = sclF & sclQ & sdaQ & ~sdaF;
  assign stopEv   = sclF & sclQ & ~sdaQ & sdaF;
  assign byteDone = (bitCnt == BC_W'(BYTE_W));
  assign addrHit  = (rxByte[7:1] == {OWN_ADDR_HI, addrSel}) || (rxByte[7:1] == ALT_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      readMode <= 1'b0;
      mAck     <= 1'b0;
    end else if (lockout) begin
      state  <= S_IDLE;
      bitCnt <= '0;
    end else if (startEv) begin
      state  <= S_ADDR;
      bitCnt <= '0;
    end else if (stopEv) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && byteDone) begin
            if (addrHit) begin
              state    <= S_AACK;
              readMode <= rxByte[0];
            end else begin
              state <= S_SKIP;
            end
          end
        end
        S_AACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= readMode ? S_RDAT : S_WDAT;
        end
        S_WDAT: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && byteDone) state <= S_WACK;
        end
        S_WACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= S_WDAT;
        end
        S_RDAT: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && byteDone) state <= S_RACK;
        end
        S_RACK: begin
          if (sclRise) mAck <= ~sdaF;
          else if (sclFall) begin
            if (mAck) begin
              state  <= S_RDAT;
              bitCnt <= '0;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.rxBit   = sdaF;
    stb.shiftIn = ~lockout & sclRise & ((state == S_ADDR) | (state == S_WDAT));
    stb.commit  = ~lockout & sclFall & byteDone & (state == S_WDAT);
    stb.loadTx  = ~lockout & sclFall & (((state == S_AACK) & readMode) | ((state == S_RACK) & mAck));
    stb.shiftTx = ~lockout & sclFall & ~byteDone & (state == S_RDAT);
  end

  assign sdaOe = (state == S_AACK) | (state == S_WACK) | ((state == S_RDAT) & ~txMsb);

  // R1: an acknowledge of an address only follows a matching address byte
  assert_ack_on_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AACK) |-> addrHit);

  // R9: drive changes only with SCL low, unless START, STOP or lockout intervened
  assert_sda_while_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!sclF || $past(startEv || stopEv || lockout)));

  // R7: lockout silences the bus driver
  assert_lockout_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockout |=> !sdaOe);

  // R3: at most one datapath action per cycle
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.commit, stb.loadTx, stb.shiftIn, stb.shiftTx}));
endmodule

// File: rtl/ctlreg_dp.sv
module ctlreg_dp
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockout,
  input  dpStrobe_t         stb,
  input  logic              overTemp,
  input  logic              overLoad,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [CTL_W-1:0]  ctlBits
);
  localparam int PAD_W = BYTE_W - 3 - 2;

  logic [BYTE_W-1:0] rxSh, txSh;
  logic [CTL_W-1:0]  ctlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
      txSh <= '0;
    end else begin
      if (stb.shiftIn) rxSh <= {rxSh[BYTE_W-2:0], stb.rxBit};
      if (stb.loadTx) txSh <= {{PAD_W{1'b0}}, ctlReg[2:0], overTemp, overLoad};
      else if (stb.shiftTx) txSh <= {txSh[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlReg <= '0;
    else if (lockout) ctlReg <= '0;
    else if (stb.commit) ctlReg <= rxSh[BYTE_W-1:BYTE_W-CTL_W];
  end

  assign rxByte  = rxSh;
  assign txMsb   = txSh[BYTE_W-1];
  assign ctlBits = ctlReg;

  // R3: control register moves only on a committed byte or lockout
  assert_ctl_write_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctlReg) |-> $past(stb.commit || lockout));

  // R7: lockout clears the register
  assert_lockout_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockout |=> (ctlReg == '0));
endmodule

// File: rtl/ctl_reg_i2c_target.sv
module ctl_reg_i2c_target
  import ctlreg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [5:0] OWN_ADDR_HI = 6'b000101,
  parameter logic [6:0] ALT_ADDR    = 7'b0001000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrStrap,
  input  logic lockout,
  input  logic overTemp,
  input  logic overLoad,
  output logic sdaOe,
  output logic limitStatic,
  output logic toneGate,
  output logic toneCont,
  output logic lineBoost,
  output logic voltHigh,
  output logic powerEn
);
  logic [1:0]        cleanLines;
  dpStrobe_t         stb;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;
  logic [CTL_W-1:0]  ctlBits;

  ctlreg_linefilt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .LINES(2)) u_filt (
    .clk(clk), .rstN(rstN), .rawIn({sclIn, sdaIn}), .cleanOut(cleanLines));

  ctlreg_ctrl #(.OWN_ADDR_HI(OWN_ADDR_HI), .ALT_ADDR(ALT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .lockout(lockout), .sclF(cleanLines[1]), .sdaF(cleanLines[0]),
    .addrSel(addrStrap), .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe));

  ctlreg_dp u_dp (
    .clk(clk), .rstN(rstN), .lockout(lockout), .stb(stb), .overTemp(overTemp),
    .overLoad(overLoad), .rxByte(rxByte), .txMsb(txMsb), .ctlBits(ctlBits));

  assign {limitStatic, toneGate, toneCont, lineBoost, voltHigh, powerEn} = ctlBits;
endmodule

// File: tb/ctl_reg_i2c_target_bench.sv
module ctl_reg_i2c_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 20;
  localparam int SETTLE     = 12;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic addrStrap = 1'b0, lockout = 1'b0, overTemp = 1'b0, overLoad = 1'b0;
  logic sdaOe, limitStatic, toneGate, toneCont, lineBoost, voltHigh, powerEn;
  logic sdaLine;

  int  cyc = 0, lastChange = 0, vecs = 0, miss = 0;
  bit  running = 1'b0, done = 1'b0;
  logic       expOe = 1'b0;
  logic [5:0] expCtl = 6'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  ctl_reg_i2c_target u_ctl_reg_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrStrap(addrStrap),
    .lockout(lockout), .overTemp(overTemp), .overLoad(overLoad), .sdaOe(sdaOe),
    .limitStatic(limitStatic), .toneGate(toneGate), .toneCont(toneCont),
    .lineBoost(lineBoost), .voltHigh(voltHigh), .powerEn(powerEn));

  wire [5:0] ctlOut = {limitStatic, toneGate, toneCont, lineBoost, voltHigh, powerEn};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (running && rstN && (cyc - lastChange > SETTLE)) begin
      chk(sdaOe == expOe, "R9 sda drive", int'(sdaOe), int'(expOe));
      chk(ctlOut == expCtl, "R2 control outputs", int'(ctlOut), int'(expCtl));
    end
  end

  task automatic mark(); lastChange = cyc; endtask
  task automatic waitQ(); repeat (QTR) @(posedge clk); endtask
  task automatic setScl(input logic v); sclM = v; mark(); endtask
  task automatic setSda(input logic v); sdaM = v; mark(); endtask

  task automatic busStart();
    setSda(1); waitQ(); setScl(1); waitQ(); setSda(0); waitQ(); setScl(0); expOe = 1'b0; waitQ();
  endtask

  task automatic busStop();
    setSda(0); waitQ(); setScl(1); waitQ(); setSda(1); waitQ();
  endtask

  // host sends one byte; glitchAt selects a bit that gets a 1-cycle SCL pulse
  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit doCommit,
                          input bit nextOe, input int glitchAt, input string tag);
    for (int i = 7; i >= 0; i--) begin
      setSda(b[i]); waitQ();
      if (i == glitchAt) begin
        sclM = 1'b1; @(posedge clk); sclM = 1'b0; mark(); waitQ();
      end
      setScl(1); waitQ();
      setScl(0);
      if (i == 0) begin
        expOe = expAck;
        if (doCommit && expAck) expCtl = b[7:2];
      end
      waitQ();
    end
    setSda(1); waitQ(); setScl(1); waitQ();
    chk(sdaLine == !expAck, tag, int'(sdaLine), int'(!expAck));
    setScl(0); expOe = nextOe; waitQ();
  endtask

  task automatic readByte(input logic [7:0] exp, input bit hostAck, input bit nextOe,
                          input int flipAt, input logic [1:0] newFlags);
    for (int i = 7; i >= 0; i--) begin
      setSda(1);
      if (i == flipAt) {overTemp, overLoad} = newFlags;
      waitQ(); setScl(1); waitQ();
      chk(sdaLine == exp[i], "R4 read bit", int'(sdaLine), int'(exp[i]));
      setScl(0);
      expOe = (i > 0) ? !exp[i-1] : 1'b0;
      waitQ();
    end
    setSda(!hostAck); waitQ(); setScl(1); waitQ(); setScl(0); expOe = nextOe; waitQ();
    setSda(1);
  endtask

  function automatic logic [7:0] readImage(input logic [1:0] flags);
    return {3'b000, expCtl[2:0], flags};
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miss++;
    $display("FAIL R3 watchdog actual=hung expected=complete");
    finishRun();
  end

  initial begin
    logic [7:0] img;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(ctlOut == 6'b0, "R8 reset controls", int'(ctlOut), 0);
    chk(sdaOe == 1'b0, "R8 reset sda released", int'(sdaOe), 0);
    rstN = 1'b1; mark(); running = 1'b1;
    repeat (10) @(posedge clk);

    // R1 R2: strap low address, test bits dropped
    busStart();
    sendByte(8'h14, 1, 0, 0, -1, "R1 ack strap-low address");
    sendByte(8'b1010_1111, 1, 1, 0, -1, "R3 ack data byte");
    busStop();
    @(negedge clk);
    chk(ctlOut == 6'b101011, "R2 write layout", int'(ctlOut), 'h2B);

    // R4 R5: read with over-temperature set, host NACK
    {overTemp, overLoad} = 2'b10; mark();
    busStart();
    img = readImage(2'b10);
    sendByte(8'h15, 1, 0, !img[7], -1, "R1 ack read address");
    readByte(img, 0, 0, -1, 2'b10);
    chk(img == 8'h0E, "R4 read image model", int'(img), 'h0E);
    busStop();

    // R1 R3: fixed alternate address, two bytes in one transaction
    busStart();
    sendByte(8'h10, 1, 0, 0, -1, "R1 ack alternate address");
    sendByte(8'b0101_0100, 1, 1, 0, -1, "R3 first data byte");
    @(negedge clk);
    chk(ctlOut == 6'b010101, "R3 first byte applied", int'(ctlOut), 'h15);
    sendByte(8'b0000_0101, 1, 1, 0, -1, "R3 second data byte");
    busStop();
    @(negedge clk);
    chk(ctlOut == 6'b000001, "R3 second byte applied", int'(ctlOut), 'h01);

    // R1: strap high, old address refused and following data ignored
    addrStrap = 1'b1; mark();
    busStart();
    sendByte(8'h14, 0, 0, 0, -1, "R1 no ack wrong strap");
    sendByte(8'hFC, 0, 0, 0, -1, "R1 data ignored after refusal");
    busStop();
    @(negedge clk);
    chk(ctlOut == 6'b000001, "R1 controls untouched", int'(ctlOut), 'h01);
    busStart();
    sendByte(8'h16, 1, 0, 0, -1, "R1 ack strap-high address");
    sendByte(8'hFC, 1, 1, 0, -1, "R3 data byte");
    busStop();

    // R5 R4: two-byte read, flags change during first byte, host ACK then NACK
    {overTemp, overLoad} = 2'b01; mark();
    busStart();
    img = readImage(2'b01);
    sendByte(8'h17, 1, 0, !img[7], -1, "R5 ack read address");
    readByte(img, 1, !readImage(2'b11) [7], 4, 2'b11);
    chk(img == 8'h1D, "R4 first image", int'(img), 'h1D);
    readByte(readImage(2'b11), 0, 0, -1, 2'b11);

    // R6: repeated START into a write
    busStart();
    sendByte(8'h16, 1, 0, 0, -1, "R6 ack after repeated start");
    sendByte(8'h00, 1, 1, 0, -1, "R6 data after repeated start");
    busStop();
    @(negedge clk);
    chk(ctlOut == 6'b0, "R6 write after repeated start", int'(ctlOut), 0);

    // R10: short SCL pulse inside a data bit
    busStart();
    sendByte(8'h16, 1, 0, 0, -1, "R10 ack address");
    sendByte(8'b1000_0100, 1, 1, 0, 5, "R10 ack despite glitch");
    busStop();
    @(negedge clk);
    chk(ctlOut == 6'b100001, "R10 glitch ignored", int'(ctlOut), 'h21);

    // R7: lockout clears, refuses access, stays zero after release
    lockout = 1'b1; expCtl = 6'b0; mark();
    repeat (QTR) @(posedge clk);
    @(negedge clk);
    chk(ctlOut == 6'b0, "R7 lockout clears", int'(ctlOut), 0);
    busStart();
    sendByte(8'h16, 0, 0, 0, -1, "R7 no ack under lockout");
    sendByte(8'hFC, 0, 0, 0, -1, "R7 data ignored under lockout");
    busStop();
    @(negedge clk);
    chk(ctlOut == 6'b0, "R7 held zero", int'(ctlOut), 0);
    lockout = 1'b0; {overTemp, overLoad} = 2'b00; mark();
    repeat (QTR) @(posedge clk);
    busStart();
    img = readImage(2'b00);
    sendByte(8'h17, 1, 0, !img[7], -1, "R7 ack after release");
    readByte(img, 0, 0, -1, 2'b00);
    busStop();
    @(negedge clk);
    chk(ctlOut == 6'b0, "R7 zero after release", int'(ctlOut), 0);

    repeat (QTR) @(posedge clk);
    finishRun();
  end
endmodule